// File: doc/BRIEF.md
# Interrupt Enable Register with Per-Line Security Gating

This block holds the interrupt enables for a group of external interrupt lines plus one enable for a non-secure-check event. It sits on a simple 32-bit register bus. The stored enables can be reached through two addresses. One address only turns bits on and the other only turns bits off, so software never needs a read-modify-write sequence. Both addresses read back the same stored state. Each enable is ANDed with its incoming interrupt flag, and the results go to a downstream interrupt combiner.

A separate attribute register assigns each external line to either the secure or the non-secure world. When a bus access is marked non-secure, it sees and changes only the enable bits of lines marked non-secure. The enables of secure lines read as zero for such an access, and its writes to them are dropped without a bus error. The non-secure-check enable is open to both worlds. A write-protect input blocks every write to the two enable addresses and raises a one-cycle error pulse.

Top module: `irq_enable_regs`

## Requirements
- R1: After synchronous reset, all enables and all attribute bits are 0. The interrupt outputs and `prot_err` are 0.
- R2: A write to the set address (offset 0x10) turns on each enable whose data bit is 1 and leaves the enables under 0 bits unchanged. External line i is data bit i (bits 7:0), and the non-secure-check enable is bit 31.
- R3: A write to the clear address (offset 0x0C) turns off each enable whose data bit is 1 and leaves the enables under 0 bits unchanged. The bit positions are the same as in R2.
- R4: A read at offset 0x10 or at offset 0x0C returns the same shared enable state, with the same bit positions as in R2. `bus_rdata` is combinational while `bus_valid` is high and `bus_write` is low.
- R5: A non-secure read at 0x10 or 0x0C returns 0 in bit i for every line i whose attribute bit is 0.
- R6: A non-secure write to 0x10 or 0x0C leaves the enable of every line whose attribute bit is 0 unchanged, and raises no error.
- R7: Bit 31 (the non-secure-check enable) is set and cleared by both secure and non-secure writes.
- R8: The attribute register is 8 bits at offset 0x1C, with bit i belonging to line i (1 = non-secure). Only secure writes change it. Non-secure writes to it are ignored. Both worlds can read it in bits 7:0.
- R9: While `wr_protect` is high, writes to 0x10 and 0x0C change no enable. `prot_err` is high in the cycle after each such write, and only then.
- R10: `ext_irq[i]` equals enable i AND `ext_flag[i]`, and `nschk_irq` equals the bit-31 enable AND `nschk_flag`.
- R11: Bits 30:8 at 0x10 and 0x0C read as 0 and ignore writes. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_nonsec | input | 1 | Access is from the non-secure world |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wr_protect | input | 1 | Blocks writes to the enable addresses |
| prot_err | output | 1 | One-cycle pulse after a blocked write |
| ext_flag | input | 8 | Incoming external interrupt flags |
| nschk_flag | input | 1 | Incoming non-secure-check flag |
| ext_irq | output | 8 | Masked external interrupt requests |
| nschk_irq | output | 1 | Masked non-secure-check request |

## Verification
The bench sweeps all 256 attribute values. For each value it preloads a different enable pattern, then does non-secure set and clear writes of all ones and a non-secure read. This separates per-bit masking from whole-register masking, and it separates mask errors on reads from mask errors on writes. Secure accesses with mixed patterns, including writes of zeros and writes to reserved bits, show whether each address only sets or only clears. The interrupt outputs are compared against all 256 enable patterns, each paired with its own flag pattern. Protected writes are placed around unprotected ones so that a pulse that lasts too long, or a pulse that is missing, shows up.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NSCHK_BIT = 31;

    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_SET  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ATTR = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_SET  = 2'd2,
        SEL_ATTR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              nonsec;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
        case (addr)
            OFF_CLR:  return SEL_CLR;
            OFF_SET:  return SEL_SET;
            OFF_ATTR: return SEL_ATTR;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_alias(input reg_sel_e sel);
        return (sel == SEL_SET) || (sel == SEL_CLR);
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_en_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_nonsec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_req_t          req
);
    always_comb begin
        req.valid  = bus_valid;
        req.write  = bus_write;
        req.nonsec = bus_nonsec;
        req.sel    = decode_addr(bus_addr);
        req.wdata  = bus_wdata;
    end
endmodule

// File: rtl/irq_attr_reg.sv
module irq_attr_reg
    import irq_en_pkg::*;
#(
    parameter int N_EXT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [N_EXT-1:0] attr
);
    logic             attr_we;
    logic [N_EXT-1:0] attr_q;

    assign attr_we = req.valid && req.write && !req.nonsec && (req.sel == SEL_ATTR);

    always_ff @(posedge clk) begin
        if (rst)          attr_q <= '0;
        else if (attr_we) attr_q <= req.wdata[N_EXT-1:0];
    end

    assign attr = attr_q;

    // R8
    attr_ns_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.nonsec) |=> $stable(attr_q));
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank
    import irq_en_pkg::*;
#(
    parameter int N_EXT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [N_EXT-1:0] attr,
    input  logic             wr_protect,
    output logic [N_EXT-1:0] ext_en,
    output logic             nschk_en,
    output logic             prot_err
);
    logic             alias_wr;
    logic             wr_ok;
    logic             do_set;
    logic             do_clr;
    logic [N_EXT-1:0] en_q;
    logic [N_EXT-1:0] en_d;
    logic             nschk_q;
    logic             nschk_d;
    logic             err_q;

    assign alias_wr = req.valid && req.write && is_alias(req.sel);
    assign wr_ok    = alias_wr && !wr_protect;
    assign do_set   = wr_ok && (req.sel == SEL_SET);
    assign do_clr   = wr_ok && (req.sel == SEL_CLR);

    for (genvar i = 0; i < N_EXT; i++) begin : g_line
        logic allow;
        assign allow   = !req.nonsec || attr[i];
        assign en_d[i] = (do_set && allow && req.wdata[i]) ? 1'b1 :
                         (do_clr && allow && req.wdata[i]) ? 1'b0 : en_q[i];
    end

    assign nschk_d = (do_set && req.wdata[NSCHK_BIT]) ? 1'b1 :
                     (do_clr && req.wdata[NSCHK_BIT]) ? 1'b0 : nschk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            nschk_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            en_q    <= en_d;
            nschk_q <= nschk_d;
            err_q   <= alias_wr && wr_protect;
        end
    end

    assign ext_en   = en_q;
    assign nschk_en = nschk_q;
    assign prot_err = err_q;

    // R2
    set_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.sel == SEL_SET)
        |=> (((en_q & $past(en_q)) == $past(en_q)) && (nschk_q || !$past(nschk_q))));

    // R3
    clr_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.sel == SEL_CLR)
        |=> (((en_q & ~$past(en_q)) == '0) && (!nschk_q || $past(nschk_q))));

    // R6
    ns_secure_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.nonsec)
        |=> (((en_q ^ $past(en_q)) & ~$past(attr)) == '0));

    // R9
    protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alias_wr && wr_protect) |=> ($stable(en_q) && $stable(nschk_q) && err_q));

    // R9
    err_only_after_block_chk: assert property (@(posedge clk) disable iff (rst)
        !(alias_wr && wr_protect) |=> !err_q);
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_en_pkg::*;
#(
    parameter int N_EXT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_nonsec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wr_protect,
    output logic              prot_err,
    input  logic [N_EXT-1:0]  ext_flag,
    input  logic              nschk_flag,
    output logic [N_EXT-1:0]  ext_irq,
    output logic              nschk_irq
);
    localparam int PAD_W  = NSCHK_BIT - N_EXT;
    localparam int ATTR_W = DATA_W - N_EXT;

    bus_req_t         req;
    logic [N_EXT-1:0] attr;
    logic [N_EXT-1:0] ext_en;
    logic             nschk_en;
    logic [N_EXT-1:0] visible;
    logic             unused_wdata;

    irq_bus_decode u_decode (
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_nonsec (bus_nonsec),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .req        (req)
    );

    irq_attr_reg #(.N_EXT(N_EXT)) u_attr (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .attr (attr)
    );

    irq_en_bank #(.N_EXT(N_EXT)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .attr       (attr),
        .wr_protect (wr_protect),
        .ext_en     (ext_en),
        .nschk_en   (nschk_en),
        .prot_err   (prot_err)
    );

    assign unused_wdata = ^req.wdata[NSCHK_BIT-1:N_EXT];
    assign visible      = req.nonsec ? attr : '1;

    always_comb begin
        bus_rdata = '0;
        if (req.valid && !req.write) begin
            case (req.sel)
                SEL_SET, SEL_CLR: bus_rdata = {nschk_en, {PAD_W{1'b0}}, ext_en & visible};
                SEL_ATTR:         bus_rdata = {{ATTR_W{1'b0}}, attr};
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign ext_irq   = ext_en & ext_flag;
    assign nschk_irq = nschk_en & nschk_flag;

    // R5
    ns_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.write && req.nonsec && is_alias(req.sel))
        |-> ((bus_rdata[N_EXT-1:0] & ~attr) == '0));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[NSCHK_BIT-1:N_EXT] == '0);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((ext_irq & ~ext_flag) == '0) && (!nschk_irq || nschk_flag));
endmodule

// File: tb/tb_irq_enable_regs.sv
module tb_irq_enable_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write, bus_nonsec;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wr_protect, prot_err;
    logic [7:0]  ext_flag, ext_irq;
    logic        nschk_flag, nschk_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] m_en;
    logic       m_ns;
    logic [7:0] m_attr;

    always #2 clk = ~clk;

    irq_enable_regs dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_nonsec(bus_nonsec), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wr_protect(wr_protect), .prot_err(prot_err),
        .ext_flag(ext_flag), .nschk_flag(nschk_flag), .ext_irq(ext_irq),
        .nschk_irq(nschk_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic ns);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_nonsec = ns;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic ns, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_nonsec = ns;
        #1 d = bus_rdata;
        bus_valid = 0;
    endtask

    function automatic logic [31:0] img(input logic [7:0] mask);
        return {m_ns, 23'b0, m_en & mask};
    endfunction

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  q;
        logic [7:0]  f;
        rst = 1; bus_valid = 0; bus_write = 0; bus_nonsec = 0; bus_addr = 0;
        bus_wdata = 0; wr_protect = 0; ext_flag = 8'hFF; nschk_flag = 1;
        m_en = 0; m_ns = 0; m_attr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_rd(8'h10, 0, rd); chk("R1 enables", rd, 32'h0);
        bus_rd(8'h1C, 0, rd); chk("R1 attr", rd, 32'h0);
        chk("R1 irq", {23'b0, nschk_irq, ext_irq}, 32'h0);
        chk("R1 prot_err", {31'b0, prot_err}, 32'h0);

        // R2 / R11 set with reserved bits
        bus_wr(8'h10, 32'hFFFF_FFFF, 0); m_en = 8'hFF; m_ns = 1;
        bus_rd(8'h10, 0, rd); chk("R2 R11 set all", rd, 32'h8000_00FF);
        bus_rd(8'h0C, 0, rd); chk("R4 clr alias read", rd, 32'h8000_00FF);
        bus_rd(8'h14, 0, rd); chk("R11 unmapped", rd, 32'h0);

        // R3 clear pattern, zeros no effect
        bus_wr(8'h0C, 32'h0000_00A5, 0); m_en = 8'h5A;
        bus_rd(8'h10, 0, rd); chk("R3 clear pattern", rd, img(8'hFF));
        bus_wr(8'h10, 32'h0, 0);
        bus_rd(8'h0C, 0, rd); chk("R2 zeros no effect", rd, img(8'hFF));
        bus_wr(8'h0C, 32'h0, 0);
        bus_rd(8'h10, 0, rd); chk("R3 zeros no effect", rd, img(8'hFF));
        bus_wr(8'h0C, 32'h8000_0000, 0); m_ns = 0;
        bus_rd(8'h10, 0, rd); chk("R3 clear bit31", rd, img(8'hFF));

        // R5 R6 R8 exhaustive attribute sweep
        for (int a = 0; a < 256; a++) begin
            m_attr = 8'(a);
            bus_wr(8'h1C, {24'b0, m_attr}, 0);
            q = 8'((a * 53 + 7) & 8'hFF);
            bus_wr(8'h0C, 32'h8000_00FF, 0);
            bus_wr(8'h10, {24'b0, q}, 0); m_en = q; m_ns = 0;
            bus_rd(8'h0C, 1, rd); chk("R5 ns read masked", rd, img(m_attr));
            bus_wr(8'h10, 32'h0000_00FF, 1); m_en = m_en | m_attr;
            bus_rd(8'h10, 0, rd); chk("R6 ns set masked", rd, img(8'hFF));
            chk("R6 no error", {31'b0, prot_err}, 32'h0);
            bus_wr(8'h0C, 32'h0000_00FF, 1); m_en = m_en & ~m_attr;
            bus_rd(8'h10, 0, rd); chk("R6 ns clr masked", rd, img(8'hFF));
            if (a % 2 == 0) begin
                bus_wr(8'h1C, {24'b0, ~m_attr}, 1);
                bus_rd(8'h1C, 1, rd); chk("R8 ns attr write ignored", rd, {24'b0, m_attr});
            end
        end

        // R7 bit 31 from non-secure side
        bus_wr(8'h1C, 32'h0, 0); m_attr = 0;
        bus_wr(8'h10, 32'h8000_0000, 1); m_ns = 1;
        bus_rd(8'h10, 1, rd); chk("R7 ns set bit31", rd, img(m_attr));
        bus_wr(8'h0C, 32'h8000_0000, 1); m_ns = 0;
        bus_rd(8'h10, 0, rd); chk("R7 ns clr bit31", rd, img(8'hFF));

        // R9 write protect
        bus_wr(8'h10, 32'h0000_003C, 0); m_en = m_en | 8'h3C;
        chk("R9 no pulse unprotected", {31'b0, prot_err}, 32'h0);
        wr_protect = 1;
        bus_wr(8'h10, 32'h8000_00FF, 0);
        chk("R9 pulse after set", {31'b0, prot_err}, 32'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, prot_err}, 32'h0);
        bus_wr(8'h0C, 32'h8000_00FF, 1);
        chk("R9 pulse after clr", {31'b0, prot_err}, 32'h1);
        wr_protect = 0;
        bus_rd(8'h10, 0, rd); chk("R9 state held", rd, img(8'hFF));
        chk("R9 pulse ended", {31'b0, prot_err}, 32'h0);

        // R10 output gating sweep
        for (int e = 0; e < 256; e++) begin
            bus_wr(8'h0C, 32'h8000_00FF, 0);
            bus_wr(8'h10, {e[0], 23'b0, 8'(e)}, 0);
            f = 8'((e * 29 + 3) & 8'hFF);
            ext_flag = f; nschk_flag = e[1];
            #1;
            chk("R10 irq gating", {23'b0, nschk_irq, ext_irq},
                {23'b0, e[0] & e[1], 8'(e) & f});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule